// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Split Interrupts

This block is a small asynchronous serial transceiver for a simple 32-bit register bus. A bus access is a single-cycle strobe that carries an address, a write flag and write data. Read data is returned combinationally in the same cycle. The port moves 8-bit characters in a fixed framing: one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity and no flow control. Each direction buffers exactly one character. Transmit uses a holding byte that feeds a shift register. Receive uses one holding byte that is filled by a mid-bit sampler placed behind a two-flop synchronizer.

Software programs the bit period in clock cycles through a divisor register. It enables each direction and each interrupt source in a control register. Four event flags are raised by hardware and cleared by writing ones. The flags drive separate receive, transmit and overrun interrupt lines, and a fourth line is the OR of those three. The register offsets are 0x00 for the character data, 0x04 for state, 0x08 for control, 0x0C for the event flags and 0x10 for the divisor.

Top module: `mmio_uart`

## Requirements
- R1: After reset, control, state and event flags read 0, the divisor reads 16, `ser_tx` is high and all four interrupt outputs are low.
- R2: The divisor register at 0x10 keeps bits 20:0 of the write and ignores higher bits. A value below 16 is stored as 16. One serial bit lasts exactly that many clock cycles.
- R3: While control bit 0 (transmit enable) is set, a held byte is sent on `ser_tx` as a low start bit, eight data bits LSB first and a high stop bit. The line idles high, and nothing is sent while bit 0 is clear.
- R4: A write to 0x00 loads the transmit holding byte and sets state bit 0 (transmit full). If state bit 0 is already set, the write is discarded and transmit overrun is flagged in state bit 2 and event bit 2.
- R5: When the held byte moves into the shifter, state bit 0 clears and event bit 0 is set. `irq_tx` is event bit 0 AND control bit 2.
- R6: While control bit 1 (receive enable) is set, `ser_rx` is synchronised through two flops. A start bit must still be low half a bit after the falling edge, so shorter low pulses are ignored. Data is sampled mid-bit, LSB first. A frame with a high stop bit stores the byte, sets state bit 1 and event bit 1, and `irq_rx` is event bit 1 AND control bit 3.
- R7: A read of 0x00 returns the received byte in bits 7:0 and clears state bit 1.
- R8: A character that completes while state bit 1 is set is discarded, the stored byte is kept, and receive overrun is flagged in state bit 3 and event bit 3.
- R9: While control bit 1 is clear, activity on `ser_rx` stores nothing and raises no flag.
- R10: Writing a 1 to an event bit at 0x0C clears that flag (clearing state bits 2 and 3 as well for the overrun flags). A 0 leaves the flag alone, and a new event in the same cycle wins over the clear.
- R11: `irq_ovr` is (event bit 2 AND control bit 4) OR (event bit 3 AND control bit 5). `irq_any` is the OR of `irq_rx`, `irq_tx` and `irq_ovr`. A flag whose enable is clear drives no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line, asynchronous |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_ovr | output | 1 | Overrun interrupt, either direction |
| irq_any | output | 1 | OR of the three interrupt lines |

## Verification
The bench aims at the single-entry buffers. It issues a second write while transmit is held off, which must leave the first byte intact on the wire: a design that overwrote the holding byte would send the second byte instead. It also lets a second character arrive before the first is read, which must keep the first byte: a design that stored the newer byte would return it. A three-cycle low glitch on the receive line checks start validation, since a receiver without the half-bit check would capture a byte of ones. Masked flags, write-one-to-clear with zero bits present, divisor clamping and a non-power-of-two divisor test the interrupt gating and the bit timing. Random bytes are sent in both directions against bench-computed frames.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_STAT = 4;
   localparam int unsigned OFS_CTRL = 8;
   localparam int unsigned OFS_EVNT = 12;
   localparam int unsigned OFS_BAUD = 16;

   // control bits, bit 0 at the bottom
   typedef struct packed {
      logic rxo_ie;
      logic txo_ie;
      logic rx_ie;
      logic tx_ie;
      logic rx_en;
      logic tx_en;
   } ctrl_t;

   // event flags, bit 0 at the bottom
   typedef struct packed {
      logic rx_ovr;
      logic tx_ovr;
      logic rx;
      logic tx;
   } evnt_t;
endpackage

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
   parameter int DIV_W     = 21,
   parameter int DATA_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DIV_W-1:0]     div,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] load_byte,
   output logic                 busy,
   output logic                 txd
);
   localparam int FRAME = DATA_BITS + 2;
   localparam int CNT_W = $clog2(FRAME + 1);

   logic [DATA_BITS:0] shreg_q;
   logic [CNT_W-1:0]   left_q;
   logic [DIV_W-1:0]   tick_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '1;
         left_q  <= '0;
         tick_q  <= '0;
         busy    <= 1'b0;
         txd     <= 1'b1;
      end else if (!busy) begin
         if (load) begin
            shreg_q <= {1'b1, load_byte};
            left_q  <= CNT_W'(FRAME - 1);
            tick_q  <= div - 1'b1;
            busy    <= 1'b1;
            txd     <= 1'b0;
         end
      end else if (tick_q != '0) begin
         tick_q <= tick_q - 1'b1;
      end else if (left_q == '0) begin
         busy <= 1'b0;
         txd  <= 1'b1;
      end else begin
         txd     <= shreg_q[0];
         shreg_q <= {1'b1, shreg_q[DATA_BITS:1]};
         left_q  <= left_q - 1'b1;
         tick_q  <= div - 1'b1;
      end
   end

   a_r3_idle_high : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);
   a_r3_start_low : assert property (@(posedge clk) disable iff (!rst_n)
      (load && !busy) |=> (busy && !txd));
endmodule

// File: rtl/uart_rx_sample.sv
module uart_rx_sample #(
   parameter int DIV_W       = 21,
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [DIV_W-1:0]     div,
   input  logic                 rxd_async,
   output logic                 done,
   output logic [DATA_BITS-1:0] data
);
   localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

   typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_st_t;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rxs;
   rx_st_t                 st_q;
   logic [DIV_W-1:0]       tick_q;
   logic [IDX_W-1:0]       idx_q;
   logic [DATA_BITS-1:0]   shreg_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_rx_sample: SYNC_STAGES must be at least 2");
      end
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b1;
            else        sync_q[s] <= (s == 0) ? rxd_async : sync_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate
   assign rxs = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         tick_q  <= '0;
         idx_q   <= '0;
         shreg_q <= '0;
         data    <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            st_q <= S_IDLE;
         end else if (st_q == S_IDLE) begin
            if (!rxs) begin
               st_q   <= S_START;
               tick_q <= (div >> 1) - 1'b1;
            end
         end else if (tick_q != '0) begin
            tick_q <= tick_q - 1'b1;
         end else begin
            tick_q <= div - 1'b1;
            case (st_q)
               S_START: begin
                  idx_q <= '0;
                  st_q  <= rxs ? S_IDLE : S_DATA;
               end
               S_DATA: begin
                  shreg_q <= {rxs, shreg_q[DATA_BITS-1:1]};
                  if (idx_q == IDX_W'(DATA_BITS - 1)) st_q <= S_STOP;
                  else                                 idx_q <= idx_q + 1'b1;
               end
               default: begin
                  st_q <= S_IDLE;
                  if (rxs) begin
                     done <= 1'b1;
                     data <= shreg_q;
                  end
               end
            endcase
         end
      end
   end

   a_r6_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_quiet_when_off : assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !done);
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart #(
   parameter int DIV_W       = 21,
   parameter int DIV_MIN     = 16,
   parameter int DATA_BITS   = 8,
   parameter int ADDR_W      = 5,
   parameter int BUS_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              ser_tx,
   input  logic              ser_rx,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              irq_ovr,
   output logic              irq_any
);
   import uart_mm_pkg::*;

   localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(DIV_MIN);
   localparam int CTRL_W = $bits(ctrl_t);
   localparam int EVNT_W = $bits(evnt_t);

   generate
      if (DIV_MIN < 4 || DIV_MIN >= (1 << DIV_W)) begin : g_bad_div
         $error("mmio_uart: DIV_MIN out of range for DIV_W");
      end
      if (BUS_W < DIV_W || BUS_W < DATA_BITS || BUS_W < CTRL_W) begin : g_bad_bus
         $error("mmio_uart: BUS_W too narrow");
      end
      if ((1 << ADDR_W) <= OFS_BAUD) begin : g_bad_addr
         $error("mmio_uart: ADDR_W too narrow for the register map");
      end
   endgenerate

   ctrl_t                ctrl_q;
   evnt_t                evnt_q, evnt_set, evnt_clr;
   logic [DIV_W-1:0]     div_q, div_wr;
   logic [DATA_BITS-1:0] hold_q, rx_q, rx_data;
   logic                 hold_full_q, rx_full_q;
   logic                 tx_busy, tx_load, rx_done;
   logic                 wr_data, wr_ctrl, wr_evnt, wr_baud, rd_data;
   logic                 rx_accept, rx_ovr_set, tx_ovr_set;

   assign wr_data = bus_sel && bus_write  && (bus_addr == ADDR_W'(OFS_DATA));
   assign wr_ctrl = bus_sel && bus_write  && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_evnt = bus_sel && bus_write  && (bus_addr == ADDR_W'(OFS_EVNT));
   assign wr_baud = bus_sel && bus_write  && (bus_addr == ADDR_W'(OFS_BAUD));
   assign rd_data = bus_sel && !bus_write && (bus_addr == ADDR_W'(OFS_DATA));

   assign tx_load    = ctrl_q.tx_en && hold_full_q && !tx_busy;
   assign tx_ovr_set = wr_data && hold_full_q && !tx_load;
   assign rx_accept  = rx_done && (!rx_full_q || rd_data);
   assign rx_ovr_set = rx_done && rx_full_q && !rd_data;
   assign evnt_set   = '{rx_ovr: rx_ovr_set, tx_ovr: tx_ovr_set, rx: rx_accept, tx: tx_load};
   assign evnt_clr   = wr_evnt ? evnt_t'(bus_wdata[EVNT_W-1:0]) : '0;
   assign div_wr     = bus_wdata[DIV_W-1:0];

   uart_tx_shift #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_tx (
      .clk(clk), .rst_n(rst_n), .div(div_q), .load(tx_load),
      .load_byte(hold_q), .busy(tx_busy), .txd(ser_tx));

   uart_rx_sample #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.rx_en), .div(div_q),
      .rxd_async(ser_rx), .done(rx_done), .data(rx_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         evnt_q      <= '0;
         div_q       <= DIV_FLOOR;
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         rx_q        <= '0;
         rx_full_q   <= 1'b0;
      end else begin
         evnt_q <= (evnt_q & ~evnt_clr) | evnt_set;
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (wr_baud) div_q  <= (div_wr < DIV_FLOOR) ? DIV_FLOOR : div_wr;
         if (wr_data && (!hold_full_q || tx_load)) begin
            hold_q      <= bus_wdata[DATA_BITS-1:0];
            hold_full_q <= 1'b1;
         end else if (tx_load) begin
            hold_full_q <= 1'b0;
         end
         if (rx_accept) begin
            rx_q      <= rx_data;
            rx_full_q <= 1'b1;
         end else if (rd_data) begin
            rx_full_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_DATA): bus_rdata = BUS_W'(rx_q);
         ADDR_W'(OFS_STAT): bus_rdata = BUS_W'({evnt_q.rx_ovr, evnt_q.tx_ovr, rx_full_q, hold_full_q});
         ADDR_W'(OFS_CTRL): bus_rdata = BUS_W'(ctrl_q);
         ADDR_W'(OFS_EVNT): bus_rdata = BUS_W'(evnt_q);
         ADDR_W'(OFS_BAUD): bus_rdata = BUS_W'(div_q);
         default:           bus_rdata = '0;
      endcase
   end

   assign irq_tx  = evnt_q.tx && ctrl_q.tx_ie;
   assign irq_rx  = evnt_q.rx && ctrl_q.rx_ie;
   assign irq_ovr = (evnt_q.tx_ovr && ctrl_q.txo_ie) || (evnt_q.rx_ovr && ctrl_q.rxo_ie);
   assign irq_any = irq_tx || irq_rx || irq_ovr;

   a_r2_div_floor : assert property (@(posedge clk) disable iff (!rst_n)
      div_q >= DIV_FLOOR);
   a_r4_drop_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && hold_full_q && !tx_busy == 1'b0) |=> (hold_q == $past(hold_q)) && evnt_q.tx_ovr);
   a_r5_load_flag : assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> evnt_q.tx && tx_busy);
   a_r7_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> !rx_full_q);
   a_r8_keep_first : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full_q && !rd_data) |=> evnt_q.rx_ovr && $stable(rx_q));
endmodule

// File: tb/tb_mmio_uart.sv
module tb_mmio_uart;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_write = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ser_tx, irq_rx, irq_tx, irq_ovr, irq_any;
   logic        ser_rx = 1'b1;
   int checks = 0, fails = 0, cyc = 0;

   localparam logic [4:0] A_DATA = 5'h00, A_STAT = 5'h04, A_CTRL = 5'h08,
                          A_EVNT = 5'h0C, A_BAUD = 5'h10;

   mmio_uart dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ser_tx(ser_tx), .ser_rx(ser_rx), .irq_rx(irq_rx), .irq_tx(irq_tx),
      .irq_ovr(irq_ovr), .irq_any(irq_any));

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, act=%0d exp<=150000 cycles", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] exp_state(bit txf, bit rxf, bit txo, bit rxo);
      return {28'd0, rxo, txo, rxf, txf};
   endfunction

   function automatic logic [31:0] exp_div(logic [31:0] w);
      logic [31:0] m = w & 32'h1F_FFFF;
      return (m < 16) ? 32'd16 : m;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic expect_reg(logic [4:0] a, logic [31:0] exp, string req);
      logic [31:0] d;
      bus_rd(a, d);
      check(d === exp, req, d, exp);
   endtask

   task automatic capture_tx(int div, output logic [7:0] b, output bit ok);
      int n = 0;
      ok = 1'b1; b = '0;
      while (ser_tx !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
      if (n >= 20000) ok = 1'b0;
      repeat (div / 2) @(negedge clk);
      if (ser_tx !== 1'b0) ok = 1'b0;
      for (int i = 0; i < 8; i++) begin
         repeat (div) @(negedge clk);
         b[i] = ser_tx;
      end
      repeat (div) @(negedge clk);
      if (ser_tx !== 1'b1) ok = 1'b0;
   endtask

   task automatic send_rx(int div, logic [7:0] b);
      @(negedge clk); ser_rx = 1'b0;
      repeat (div) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         ser_rx = b[i];
         repeat (div) @(negedge clk);
      end
      ser_rx = 1'b1;
      repeat (div + 4) @(negedge clk);
   endtask

   task automatic tx_byte(int div, logic [7:0] v, string req);
      logic [7:0] got; bit ok;
      fork
         bus_wr(A_DATA, {24'd0, v});
         capture_tx(div, got, ok);
      join
      check(ok && got === v, req, {23'd0, ok, got}, {23'd0, 1'b1, v});
   endtask

   initial begin
      logic [31:0] d;
      logic [7:0]  got, va, vb;
      bit          ok;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(ser_tx === 1'b1 && {irq_rx, irq_tx, irq_ovr, irq_any} === 4'b0, "R1 lines",
            {27'd0, ser_tx, irq_rx, irq_tx, irq_ovr, irq_any}, 32'h10);
      expect_reg(A_CTRL, 32'd0, "R1 ctrl");
      expect_reg(A_STAT, exp_state(0, 0, 0, 0), "R1 state");
      expect_reg(A_EVNT, 32'd0, "R1 events");
      expect_reg(A_BAUD, 32'd16, "R1 divisor");

      // R2 divisor clamp and masking
      bus_wr(A_BAUD, 32'd5);
      expect_reg(A_BAUD, exp_div(32'd5), "R2 clamp");
      bus_wr(A_BAUD, 32'hFFFF_FFFF);
      expect_reg(A_BAUD, exp_div(32'hFFFF_FFFF), "R2 mask");
      bus_wr(A_BAUD, 32'd16);

      // R3 nothing sent while transmit disabled; R4 second write dropped
      bus_wr(A_CTRL, 32'h10);
      bus_wr(A_DATA, 32'h5A);
      bus_wr(A_DATA, 32'hC3);
      repeat (40) @(negedge clk);
      check(ser_tx === 1'b1, "R3 disabled idle", {31'd0, ser_tx}, 32'd1);
      expect_reg(A_STAT, exp_state(1, 0, 1, 0), "R4 overrun state");
      check(irq_ovr === 1'b1 && irq_any === 1'b1, "R11 ovr line",
            {30'd0, irq_ovr, irq_any}, 32'd3);
      fork
         bus_wr(A_CTRL, 32'h15);
         capture_tx(16, got, ok);
      join
      check(ok && got === 8'h5A, "R4 first byte kept", {23'd0, ok, got}, 32'h15A);
      expect_reg(A_STAT, exp_state(0, 0, 1, 0), "R5 holding empty");
      expect_reg(A_EVNT, 32'h5, "R5 tx event");
      check(irq_tx === 1'b1, "R5 irq_tx", {31'd0, irq_tx}, 32'd1);
      bus_wr(A_EVNT, 32'h4);
      expect_reg(A_EVNT, 32'h1, "R10 clear one bit");
      check(irq_ovr === 1'b0 && irq_tx === 1'b1, "R11 after clear",
            {30'd0, irq_ovr, irq_tx}, 32'd1);
      bus_wr(A_EVNT, 32'hF);
      check(irq_any === 1'b0, "R10 all cleared", {31'd0, irq_any}, 32'd0);

      // R3 random bytes out
      for (int k = 0; k < 6; k++) begin
         va = 8'($urandom);
         tx_byte(16, va, "R3 random tx");
      end

      // R9 receive disabled
      bus_wr(A_CTRL, 32'h0);
      bus_wr(A_EVNT, 32'hF);
      send_rx(16, 8'hA5);
      expect_reg(A_STAT, exp_state(0, 0, 0, 0), "R9 rx off");
      expect_reg(A_EVNT, 32'd0, "R9 no event");

      // R6 receive, masked interrupt first
      bus_wr(A_CTRL, 32'h2);
      send_rx(16, 8'h3C);
      expect_reg(A_STAT, exp_state(0, 1, 0, 0), "R6 rx full");
      check(irq_rx === 1'b0 && irq_any === 1'b0, "R11 masked rx",
            {30'd0, irq_rx, irq_any}, 32'd0);
      bus_wr(A_CTRL, 32'hA);
      check(irq_rx === 1'b1 && irq_any === 1'b1, "R6 irq_rx",
            {30'd0, irq_rx, irq_any}, 32'd3);
      expect_reg(A_DATA, 32'h3C, "R7 read byte");
      expect_reg(A_STAT, exp_state(0, 0, 0, 0), "R7 read clears full");
      bus_wr(A_EVNT, 32'h2);

      // R6 glitch shorter than half a bit
      @(negedge clk); ser_rx = 1'b0;
      repeat (3) @(negedge clk); ser_rx = 1'b1;
      repeat (200) @(negedge clk);
      expect_reg(A_STAT, exp_state(0, 0, 0, 0), "R6 glitch ignored");

      // R8 receive overrun keeps first byte
      bus_wr(A_CTRL, 32'h22);
      send_rx(16, 8'h81);
      send_rx(16, 8'h7E);
      expect_reg(A_STAT, exp_state(0, 1, 0, 1), "R8 overrun state");
      check(irq_ovr === 1'b1, "R11 rx ovr line", {31'd0, irq_ovr}, 32'd1);
      expect_reg(A_DATA, 32'h81, "R8 first byte kept");
      bus_wr(A_EVNT, 32'hF);

      // R6 random bytes in
      for (int k = 0; k < 6; k++) begin
         vb = 8'($urandom);
         send_rx(16, vb);
         expect_reg(A_DATA, {24'd0, vb}, "R6 random rx");
      end

      // R2 odd divisor in both directions
      bus_wr(A_BAUD, 32'd37);
      bus_wr(A_CTRL, 32'h3);
      tx_byte(37, 8'h96, "R2 tx div 37");
      send_rx(37, 8'h4D);
      expect_reg(A_DATA, 32'h4D, "R2 rx div 37");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule